// File: doc/BRIEF.md
# Link Pulse Remote Status Codec

This block lets two ends of a twisted-pair link exchange a small amount of status during idle time. The information is carried only in the spacing of idle link pulses. The pulses themselves carry nothing. On the transmit side, local link loss, local jabber or a plain "capable, no fault" indication each selects a repeating pattern of pulse-to-pulse gaps. For each pulse the block raises a one-cycle request to the analog driver. Whenever a frame is being sent, pulse emission is suppressed and the pattern starts again from its first gap.

On the receive side, a one-cycle strobe marks each detected link pulse. The block measures every gap in units of an external 1 ms tick and rounds each gap to one of three nominal lengths. It compares the most recent gaps with the three patterns and drives one output per remote condition. An output rises once its pattern has been seen complete twice. It drops after a long stretch in which the pattern is not seen. All pins are plain control and status levels or single-cycle strobes. There is no data stream, so there is no handshake and no back-pressure.

Top module: `lpsc_codec`

## Requirements
- R1: With `loc_down` high, the gaps between successive `pulse_req` strobes repeat 10, 15, 20 ticks, starting with 10 after reset or after a frame.
- R2: With `loc_jab` high and `loc_down` low, the gaps repeat 10, 20, 15 ticks.
- R3: With both local conditions low, the gaps repeat 10, 20 ticks.
- R4: When `loc_down` and `loc_jab` are both high, the link-down pattern is sent. The local inputs are latched when the first 10-tick gap of each pattern ends.
- R5: `pulse_req` is never high in the cycle after `tx_busy` was high, and it is never high for two cycles in a row.
- R6: A high `tx_busy` aborts the current pattern. The next pulse comes 10 ticks after `tx_busy` falls, and the pattern then continues from its second gap.
- R7: Every emitted gap lies between 8 and 24 ticks.
- R8: A received gap is counted as short, medium or long when it lies within 2 ticks of 10, 15 or 20 ticks respectively (8–12, 13–17, 18–22). Any other gap breaks the pattern.
- R9: A remote output rises on the `rx_pulse` that completes the second matching pattern, never after only one. The patterns are short-medium-long for `rmt_down`, short-long-medium for `rmt_jab`, and long-short-long for `rmt_compat`.
- R10: A remote output clears 100 ticks after the last matching pattern, and stays set for shorter silences.
- R11: All outputs are low after reset. Each remote output responds only to its own pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe once per millisecond |
| tx_busy | input | 1 | High while a frame is being transmitted |
| loc_down | input | 1 | Local link-down condition |
| loc_jab | input | 1 | Local jabber condition |
| rx_pulse | input | 1 | One-cycle strobe per received link pulse |
| pulse_req | output | 1 | One-cycle request to emit a link pulse |
| rmt_down | output | 1 | Far end reports link down |
| rmt_jab | output | 1 | Far end reports jabber |
| rmt_compat | output | 1 | Far end is capable of remote signaling |

## Verification
The transmit side is driven with each combination of the local conditions, including both high at once. Frame aborts are placed both at pattern starts and in mid-pattern, which tells the three gap orders apart and shows the restart point. The receive side gets exact nominal gaps, randomly jittered gaps within tolerance, and gaps exactly on the tolerance edges and one tick outside them. These separate correct rounding from a pattern break. Single-pattern, double-pattern and silence-length cases tell the two-pattern assertion rule from the 100-tick release.

// File: rtl/lpsc_pkg.sv
package lpsc_pkg;

  typedef enum logic [1:0] {
    SYM_BAD   = 2'd0,
    SYM_SHORT = 2'd1,
    SYM_MID   = 2'd2,
    SYM_LONG  = 2'd3
  } gap_sym_e;

  typedef enum logic [1:0] {
    ST_CAPABLE  = 2'd0,
    ST_LINKDOWN = 2'd1,
    ST_JABBER   = 2'd2
  } loc_code_e;

  localparam int unsigned N_REMOTE = 3;

  // gap symbol expected at position idx of the pattern for code c
  function automatic gap_sym_e sym_at(loc_code_e c, logic [1:0] idx);
    gap_sym_e s;
    s = SYM_SHORT;
    if (idx != 2'd0) begin
      unique case (c)
        ST_LINKDOWN: s = (idx == 2'd1) ? SYM_MID : SYM_LONG;
        ST_JABBER:   s = (idx == 2'd1) ? SYM_LONG : SYM_MID;
        default:     s = SYM_LONG;
      endcase
    end
    return s;
  endfunction

  function automatic logic [1:0] seq_last(loc_code_e c);
    return (c == ST_CAPABLE) ? 2'd1 : 2'd2;
  endfunction

endpackage

// File: rtl/lpsc_tx_seq.sv
module lpsc_tx_seq
  import lpsc_pkg::*;
#(
  parameter int CNT_W    = 6,
  parameter int SHORT_MS = 10,
  parameter int MID_MS   = 15,
  parameter int LONG_MS  = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic tx_busy,
  input  logic loc_down,
  input  logic loc_jab,
  output logic pulse_req
);

  localparam logic [CNT_W-1:0] T_SHORT = CNT_W'(SHORT_MS);
  localparam logic [CNT_W-1:0] T_MID   = CNT_W'(MID_MS);
  localparam logic [CNT_W-1:0] T_LONG  = CNT_W'(LONG_MS);

  logic [CNT_W-1:0] ms_q;
  logic [1:0]       idx_q;
  logic [1:0]       idx_nxt;
  loc_code_e        code_q;
  loc_code_e        code_sel;
  gap_sym_e         sym;
  logic [CNT_W-1:0] target;
  logic             gap_done;

  always_comb begin
    if (loc_down)     code_sel = ST_LINKDOWN;
    else if (loc_jab) code_sel = ST_JABBER;
    else              code_sel = ST_CAPABLE;

    sym = sym_at(code_q, idx_q);
    unique case (sym)
      SYM_SHORT: target = T_SHORT;
      SYM_MID:   target = T_MID;
      default:   target = T_LONG;
    endcase

    gap_done = tick && ((ms_q + 1'b1) == target);
    idx_nxt  = (idx_q == seq_last(code_q)) ? 2'd0 : idx_q + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ms_q      <= '0;
      idx_q     <= 2'd0;
      code_q    <= ST_CAPABLE;
      pulse_req <= 1'b0;
    end else if (tx_busy) begin
      ms_q      <= '0;
      idx_q     <= 2'd0;
      pulse_req <= 1'b0;
    end else if (gap_done) begin
      ms_q      <= '0;
      idx_q     <= idx_nxt;
      pulse_req <= 1'b1;
      if (idx_q == 2'd0) code_q <= code_sel;
    end else begin
      if (tick) ms_q <= ms_q + 1'b1;
      pulse_req <= 1'b0;
    end
  end

endmodule

// File: rtl/lpsc_rx_meter.sv
module lpsc_rx_meter
  import lpsc_pkg::*;
#(
  parameter int CNT_W    = 6,
  parameter int SHORT_MS = 10,
  parameter int MID_MS   = 15,
  parameter int LONG_MS  = 20,
  parameter int TOL_MS   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                rx_pulse,
  output logic [N_REMOTE-1:0] hit
);

  localparam logic [CNT_W-1:0] GAP_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] gap_q;
  gap_sym_e         cur;
  gap_sym_e         prev1_q;  // newest stored symbol
  gap_sym_e         prev2_q;  // older stored symbol

  function automatic logic near(logic [CNT_W-1:0] g, int nom);
    int gi;
    gi = int'(g);
    return (gi + TOL_MS >= nom) && (gi <= nom + TOL_MS);
  endfunction

  always_comb begin
    if (near(gap_q, SHORT_MS))     cur = SYM_SHORT;
    else if (near(gap_q, MID_MS))  cur = SYM_MID;
    else if (near(gap_q, LONG_MS)) cur = SYM_LONG;
    else                           cur = SYM_BAD;

    hit[0] = rx_pulse && (prev2_q == SYM_SHORT) && (prev1_q == SYM_MID)   && (cur == SYM_LONG);
    hit[1] = rx_pulse && (prev2_q == SYM_SHORT) && (prev1_q == SYM_LONG)  && (cur == SYM_MID);
    hit[2] = rx_pulse && (prev2_q == SYM_LONG)  && (prev1_q == SYM_SHORT) && (cur == SYM_LONG);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q   <= GAP_MAX;
      prev1_q <= SYM_BAD;
      prev2_q <= SYM_BAD;
    end else if (rx_pulse) begin
      gap_q   <= '0;
      prev1_q <= cur;
      prev2_q <= prev1_q;
    end else if (tick && gap_q != GAP_MAX) begin
      gap_q <= gap_q + 1'b1;
    end
  end

endmodule

// File: rtl/lpsc_remote_hold.sv
module lpsc_remote_hold #(
  parameter int NEED_SEQ = 2,
  parameter int HOLD_MS  = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hit,
  output logic active
);

  localparam int HW = $clog2(NEED_SEQ + 1);
  localparam int QW = $clog2(HOLD_MS + 1);
  localparam logic [HW-1:0] NEED_V = HW'(NEED_SEQ);
  localparam logic [QW-1:0] QUIET_END = QW'(HOLD_MS - 1);

  logic [HW-1:0] hits_q;
  logic [QW-1:0] quiet_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hits_q  <= '0;
      quiet_q <= '0;
      active  <= 1'b0;
    end else if (hit) begin
      quiet_q <= '0;
      if (hits_q != NEED_V) hits_q <= hits_q + 1'b1;
      if (int'(hits_q) + 1 >= NEED_SEQ) active <= 1'b1;
    end else if (tick && (active || hits_q != '0)) begin
      if (quiet_q == QUIET_END) begin
        quiet_q <= '0;
        hits_q  <= '0;
        active  <= 1'b0;
      end else begin
        quiet_q <= quiet_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/lpsc_codec.sv
module lpsc_codec
  import lpsc_pkg::*;
#(
  parameter int CNT_W    = 6,
  parameter int SHORT_MS = 10,
  parameter int MID_MS   = 15,
  parameter int LONG_MS  = 20,
  parameter int TOL_MS   = 2,
  parameter int NEED_SEQ = 2,
  parameter int HOLD_MS  = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic tx_busy,
  input  logic loc_down,
  input  logic loc_jab,
  input  logic rx_pulse,
  output logic pulse_req,
  output logic rmt_down,
  output logic rmt_jab,
  output logic rmt_compat
);

  logic [N_REMOTE-1:0] hit;
  logic [N_REMOTE-1:0] remote;

  lpsc_tx_seq #(
    .CNT_W(CNT_W), .SHORT_MS(SHORT_MS), .MID_MS(MID_MS), .LONG_MS(LONG_MS)
  ) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tx_busy(tx_busy),
    .loc_down(loc_down), .loc_jab(loc_jab), .pulse_req(pulse_req)
  );

  lpsc_rx_meter #(
    .CNT_W(CNT_W), .SHORT_MS(SHORT_MS), .MID_MS(MID_MS), .LONG_MS(LONG_MS),
    .TOL_MS(TOL_MS)
  ) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_pulse(rx_pulse), .hit(hit)
  );

  for (genvar k = 0; k < N_REMOTE; k++) begin : g_hold
    lpsc_remote_hold #(.NEED_SEQ(NEED_SEQ), .HOLD_MS(HOLD_MS)) u_hold (
      .clk(clk), .rst_n(rst_n), .tick(tick), .hit(hit[k]), .active(remote[k])
    );
  end

  assign rmt_down   = remote[0];
  assign rmt_jab    = remote[1];
  assign rmt_compat = remote[2];

endmodule

// File: rtl/lpsc_codec_chk.sv
module lpsc_codec_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic tx_busy,
  input logic loc_down,
  input logic loc_jab,
  input logic rx_pulse,
  input logic pulse_req,
  input logic rmt_down,
  input logic rmt_jab,
  input logic rmt_compat
);

  logic [5:0] since_q;

  always_ff @(posedge clk) begin
    if (!rst_n || tx_busy || pulse_req) since_q <= '0;
    else if (tick && since_q != 6'h3f)  since_q <= since_q + 1'b1;
  end

  p_single_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_req |=> !pulse_req);

  p_silent_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tx_busy) |-> !pulse_req);

  p_gap_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_req |-> (since_q >= 6'd8 && since_q <= 6'd24));

  p_down_on_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rmt_down) |-> $past(rx_pulse));

  p_jab_on_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rmt_jab) |-> $past(rx_pulse));

  p_compat_on_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rmt_compat) |-> $past(rx_pulse));

  wire unused_ok = &{1'b0, loc_down, loc_jab};

endmodule

bind lpsc_codec lpsc_codec_chk u_chk (.*);

// File: tb/lpsc_codec_bench.sv
module lpsc_codec_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic tx_busy = 1'b0;
  logic loc_down = 1'b0;
  logic loc_jab = 1'b0;
  logic rx_pulse = 1'b0;
  logic pulse_req, rmt_down, rmt_jab, rmt_compat;

  int n_chk = 0;
  int n_bad = 0;
  int tick_count = 0;
  int pulse_seen = 0;
  int tdiv = 0;

  always #10 clk = ~clk;

  lpsc_codec u_lpsc_codec (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tx_busy(tx_busy),
    .loc_down(loc_down), .loc_jab(loc_jab), .rx_pulse(rx_pulse),
    .pulse_req(pulse_req), .rmt_down(rmt_down), .rmt_jab(rmt_jab),
    .rmt_compat(rmt_compat)
  );

  // 1 ms tick = 5 clocks for a short run
  always @(negedge clk) begin
    tdiv <= (tdiv == 4) ? 0 : tdiv + 1;
    tick <= (tdiv == 4);
  end
  always @(posedge clk) if (tick) tick_count <= tick_count + 1;
  always @(negedge clk) if (pulse_req) pulse_seen <= pulse_seen + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // code: 0 capable, 1 link down, 2 jabber
  function automatic int exp_gap(input int code, input int i);
    if (code == 1) return (i % 3 == 0) ? 10 : (i % 3 == 1) ? 15 : 20;
    if (code == 2) return (i % 3 == 0) ? 10 : (i % 3 == 1) ? 20 : 15;
    return (i % 2 == 0) ? 10 : 20;
  endfunction

  function automatic int seq_len(input int code);
    return (code == 0) ? 2 : 3;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; loc_down = 1'b0; loc_jab = 1'b0; tx_busy = 1'b0; rx_pulse = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_ticks(input int n);
    int t;
    t = tick_count + n;
    while (tick_count < t) @(negedge clk);
  endtask

  task automatic next_pulse(output int stamp);
    @(negedge clk);
    while (!pulse_req) @(negedge clk);
    stamp = tick_count;
  endtask

  // abort with a frame, then measure n gaps starting at pattern position first
  task automatic tx_measure(input bit dn, input bit jb, input int n, input string req);
    int code, prev, now;
    code = dn ? 1 : (jb ? 2 : 0);
    @(negedge clk);
    loc_down = dn; loc_jab = jb; tx_busy = 1'b1;
    repeat (3) @(negedge clk);
    prev = tick_count;
    tx_busy = 1'b0;
    for (int i = 0; i < n; i++) begin
      next_pulse(now);
      chk((now - prev) == exp_gap(code, i), req, now - prev, exp_gap(code, i));
      prev = now;
    end
  endtask

  task automatic send_gap(input int n);
    wait_ticks(n);
    repeat (2) @(negedge clk);
    rx_pulse = 1'b1;
    @(negedge clk);
    rx_pulse = 1'b0;
  endtask

  task automatic rx_stream(input int code, input int reps, input bit jitter);
    int j;
    for (int i = 0; i < reps * seq_len(code); i++) begin
      j = jitter ? (int'($urandom % 5) - 2) : 0;
      send_gap(exp_gap(code, i) + j);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int s, a, b, code, base;
    void'($urandom(32'd907));
    do_reset();
    @(negedge clk);
    // R11 reset state
    chk(!pulse_req && !rmt_down && !rmt_jab && !rmt_compat, "R11 reset",
        {pulse_req, rmt_down, rmt_jab, rmt_compat}, 0);

    // R1..R4 directed patterns
    tx_measure(1'b1, 1'b0, 7, "R1 down gaps");
    tx_measure(1'b0, 1'b1, 7, "R2 jab gaps");
    tx_measure(1'b0, 1'b0, 6, "R3 compat gaps");
    tx_measure(1'b1, 1'b1, 7, "R4 priority gaps");

    // R5 no pulses while busy for 40 ticks
    @(negedge clk); tx_busy = 1'b1;
    base = pulse_seen;
    wait_ticks(40);
    chk(pulse_seen == base, "R5 busy silence", pulse_seen - base, 0);

    // R6 mid-pattern abort: after two pulses, restart at first gap
    loc_down = 1'b0; loc_jab = 1'b1; tx_busy = 1'b0;
    next_pulse(s); next_pulse(s);
    tx_measure(1'b0, 1'b1, 3, "R6 restart after abort");

    // random transmit mixes (R1..R4)
    for (int k = 0; k < 6; k++) begin
      a = $urandom % 2; b = $urandom % 2;
      tx_measure(a[0], b[0], 5, "R4 random tx");
    end

    // R9/R11/R10 receive, link down
    do_reset();
    send_gap(1);
    rx_stream(1, 1, 1'b0);
    @(negedge clk);
    chk(rmt_down == 1'b0, "R9 one pattern not enough", rmt_down, 0);
    rx_stream(1, 1, 1'b0);
    @(negedge clk);
    chk(rmt_down == 1'b1, "R9 down after two", rmt_down, 1);
    chk(!rmt_jab && !rmt_compat, "R11 others idle", {rmt_jab, rmt_compat}, 0);
    wait_ticks(60);
    chk(rmt_down == 1'b1, "R10 held at 60", rmt_down, 1);
    wait_ticks(45);
    chk(rmt_down == 1'b0, "R10 cleared after 100", rmt_down, 0);

    // R8 tolerance edges accepted
    do_reset();
    send_gap(1);
    send_gap(8); send_gap(13); send_gap(22);
    send_gap(12); send_gap(17); send_gap(18);
    @(negedge clk);
    chk(rmt_down == 1'b1, "R8 edges accepted", rmt_down, 1);

    // R8 out of tolerance long gap
    do_reset();
    send_gap(1);
    send_gap(10); send_gap(15); send_gap(23);
    send_gap(10); send_gap(15); send_gap(23);
    @(negedge clk);
    chk(rmt_down == 1'b0, "R8 gap 23 rejected", rmt_down, 0);

    // R8 out of tolerance short gap
    do_reset();
    send_gap(1);
    send_gap(10); send_gap(15); send_gap(20);
    send_gap(7); send_gap(15); send_gap(20);
    @(negedge clk);
    chk(rmt_down == 1'b0, "R8 gap 7 rejected", rmt_down, 0);

    // R9/R11 random jittered remote patterns
    for (int k = 0; k < 8; k++) begin
      code = (k < 3) ? k : int'($urandom % 3);
      do_reset();
      send_gap(1);
      rx_stream(code, (code == 0) ? 3 : 2, 1'b1);
      @(negedge clk);
      chk(rmt_down == (code == 1), "R9 random down", rmt_down, code == 1);
      chk(rmt_jab == (code == 2), "R9 random jab", rmt_jab, code == 2);
      chk(rmt_compat == (code == 0), "R11 random compat", rmt_compat, code == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule